// File: doc/BRIEF.md
# Page Write Buffer with Commit

This block sits behind a serial memory front end and turns one write frame into one programming cycle. After the front end has decoded a write opcode and its address, the block collects the data bytes of the frame. It keeps them in a one-page staging buffer with a valid flag for each slot. It also counts the data bits that arrive after the last complete byte. When chip select rises, the block checks that the rise fell exactly on a byte boundary and that at least one byte arrived. If so, it screens the staged bytes against the protection inputs and starts a self-timed busy period. If not, it drops the frame.

During the busy period the block walks the page slots in ascending order, one slot per cycle, and writes each surviving byte to the array port. The busy flag stays high for a programmable number of cycles, with a floor of one page's worth of cycles. When the busy period ends, the block clears its write-enable latch, so every write needs a fresh enable. The write-enable latch lives here because programming completion clears it. The protection policy comes from outside as a protected lower bound, an enable and a mode bit.

Top module: `page_write_commit`

## Requirements
- R1: After reset, `busy_o`, `wel_o` and `mem_we_o` are 0.
- R2: When idle, `wren_i` sets the write-enable latch and `wrdi_i` clears it, visible on `wel_o` one cycle later. A `wr_start_i` in the same cycle takes priority over both, and `wren_i` takes priority over `wrdi_i`. While `busy_o` is 1, both inputs are ignored.
- R3: A `wr_start_i` that arrives while the latch is clear is ignored. The bytes and the chip-select rise that follow it cause no busy period and no array write.
- R4: The first data byte goes to the slot given by the low 5 address bits, and each further byte goes to the next slot modulo 32. The upper address bits stay fixed for the frame. A 33rd or later byte replaces the byte staged earlier in its slot.
- R5: A commit takes place only when `cs_rise_i` arrives while zero data bits have been counted since the last complete byte (`byte_stb_i`) and at least one byte is staged. Any other rise discards the frame. It then starts no busy period, writes nothing and leaves `wel_o` unchanged.
- R6: A chip-select rise before the first complete data byte leaves the array and `wel_o` unchanged.
- R7: `busy_o` rises in the cycle after the committing `cs_rise_i` cycle. It stays high for max(`tprog_i`, 32) cycles, using the `tprog_i` value sampled at commit.
- R8: In busy cycle k (k = 0 for the first busy cycle), for k < 32, `mem_we_o` is 1 exactly when slot k holds a kept byte. `mem_addr_o` is then {page, k} and `mem_wdata_o` is the last byte staged in slot k. No array write happens outside the busy period.
- R9: With `prot_en_i` = 1 and `prot_whole_i` = 0, a staged byte whose address is at or above `prot_base_i` is dropped, and the other staged bytes are still written.
- R10: With `prot_en_i` = 1 and `prot_whole_i` = 1, if any staged byte lies at or above `prot_base_i`, the whole page is dropped. Otherwise every staged byte is written.
- R11: When screening leaves no byte to write, no busy period starts and `wel_o` keeps its value.
- R12: The write-enable latch stays set for the whole busy period and reads 0 from the cycle after busy ends.
- R13: Write starts, bits, bytes and chip-select rises that arrive during the busy period have no effect on the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start_i | input | 1 | Pulse: a write opcode and its address have been decoded |
| start_addr_i | input | ADDR_W | Start byte address of the write frame |
| bit_stb_i | input | 1 | Pulse: one data bit was shifted in |
| byte_stb_i | input | 1 | Pulse: a data byte completed; arrives with the last bit strobe |
| byte_i | input | 8 | The completed data byte |
| cs_rise_i | input | 1 | Pulse: chip select went inactive |
| wren_i | input | 1 | Pulse: set the write-enable latch |
| wrdi_i | input | 1 | Pulse: clear the write-enable latch |
| prot_en_i | input | 1 | Enables the protected range check |
| prot_whole_i | input | 1 | 1: drop the whole page on any hit; 0: drop only hit bytes |
| prot_base_i | input | ADDR_W | Lowest protected byte address |
| tprog_i | input | CNT_W | Programming time in clock cycles (floor of 32) |
| busy_o | output | 1 | Programming cycle in progress |
| wel_o | output | 1 | Write-enable latch |
| mem_we_o | output | 1 | Array byte write strobe |
| mem_addr_o | output | ADDR_W | Array byte address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
The assertions check, on every cycle, the properties that hold locally. Array writes happen only while busy. The latch holds through a busy period and drops as it ends. The slot pointer advances by one per byte inside a fixed page. A write start with the latch clear, or a rise off a byte boundary, never leads to a busy period. The busy counter also steps by one per cycle and cannot end before a full page walk. Other behaviour needs the bench scenarios and its per-cycle reference model. These cover wrap and overwrite inside a page, the two protection modes, the unchanged latch after an abort or an empty screen, the effective busy length under different `tprog_i` values, and the frames fed in during a busy period that leave no trace in the array.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [1:0] {
        PW_IDLE = 2'd0,
        PW_FILL = 2'd1,
        PW_PROG = 2'd2
    } pw_state_e;

endpackage

// File: rtl/pwb_page_store.sv
module pwb_page_store #(
    parameter int DATA_W = 8,
    parameter int SLOTS  = 32,
    parameter int IDX_W  = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              mask_i,
    input  logic [SLOTS-1:0]  keep_i,
    input  logic [IDX_W-1:0]  ridx_i,
    output logic [SLOTS-1:0]  valid_o,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic [SLOTS-1:0][DATA_W-1:0] data;
        logic [SLOTS-1:0]             valid;
    } store_t;

    store_t st_d, st_q;
    logic [SLOTS-1:0] slot_hit;

    for (genvar k = 0; k < SLOTS; k++) begin : g_hit
        assign slot_hit[k] = wr_i && (widx_i == IDX_W'(k));
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < SLOTS; k++) begin
            if (slot_hit[k]) begin
                st_d.data[k]  = wdata_i;
                st_d.valid[k] = 1'b1;
            end
        end
        if (mask_i) begin
            st_d.valid = st_q.valid & keep_i;
        end
        if (clr_i) begin
            st_d.valid = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign rdata_o = st_q.data[ridx_i];

    p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (valid_o == '0));

    p_byte_marks_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i && !mask_i) |=> valid_o[$past(widx_i)]);

    p_mask_never_adds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i && !clr_i) |=> ((valid_o & ~$past(valid_o)) == '0));

endmodule

// File: rtl/pwb_guard.sv
module pwb_guard #(
    parameter int ADDR_W = 11,
    parameter int SLOTS  = 32,
    parameter int IDX_W  = $clog2(SLOTS),
    parameter int PAGE_W = ADDR_W - IDX_W
) (
    input  logic [PAGE_W-1:0] page_i,
    input  logic [SLOTS-1:0]  valid_i,
    input  logic              prot_en_i,
    input  logic              whole_i,
    input  logic [ADDR_W-1:0] prot_base_i,
    output logic [SLOTS-1:0]  keep_o,
    output logic              any_o
);

    logic [SLOTS-1:0] in_range;
    logic             page_hit;

    for (genvar k = 0; k < SLOTS; k++) begin : g_range
        assign in_range[k] = prot_en_i && ({page_i, IDX_W'(k)} >= prot_base_i);
    end

    assign page_hit = |(valid_i & in_range);
    assign keep_o   = (whole_i && page_hit) ? '0 : (valid_i & ~in_range);
    assign any_o    = |keep_o;

endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
    parameter int CNT_W = 16,
    parameter int SLOTS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             busy_o,
    output logic [CNT_W-1:0] step_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(SLOTS);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] last;
    } tim_t;

    tim_t tim_d, tim_q;
    logic [CNT_W-1:0] eff_len;

    assign eff_len = (len_i < MIN_LEN) ? MIN_LEN : len_i;

    always_comb begin
        tim_d  = tim_q;
        done_o = tim_q.busy && (tim_q.cnt == tim_q.last);
        if (!tim_q.busy) begin
            if (start_i) begin
                tim_d.busy = 1'b1;
                tim_d.cnt  = '0;
                tim_d.last = eff_len - 1'b1;
            end
        end else if (done_o) begin
            tim_d.busy = 1'b0;
            tim_d.cnt  = '0;
        end else begin
            tim_d.cnt = tim_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim_q <= '0;
        end else begin
            tim_q <= tim_d;
        end
    end

    assign busy_o = tim_q.busy;
    assign step_o = tim_q.cnt;

    p_page_walk_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (step_o < MIN_LEN - 1'b1)) |=> busy_o);

    p_step_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> (busy_o && (step_o == $past(step_o) + 1'b1)));

    p_start_from_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (step_o == '0));

endmodule

// File: rtl/page_write_commit.sv
module page_write_commit #(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 32,
    parameter int CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              bit_stb_i,
    input  logic              byte_stb_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              cs_rise_i,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              prot_en_i,
    input  logic              prot_whole_i,
    input  logic [ADDR_W-1:0] prot_base_i,
    input  logic [CNT_W-1:0]  tprog_i,
    output logic              busy_o,
    output logic              wel_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o
);

    import pwb_pkg::*;

    localparam int IDX_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - IDX_W;
    localparam int FRAC_W = $clog2(DATA_W);

    typedef struct packed {
        pw_state_e         st;
        logic [PAGE_W-1:0] page;
        logic [IDX_W-1:0]  ptr;
        logic [FRAC_W-1:0] frac;
        logic              wel;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                  store_clr, store_wr, store_mask, tim_start;
    logic [PAGE_BYTES-1:0] slot_valid, slot_keep;
    logic                  any_keep;
    logic                  tim_busy, tim_done;
    logic [CNT_W-1:0]      tim_step;
    logic [IDX_W-1:0]      walk_idx;
    logic [DATA_W-1:0]     walk_data;

    assign walk_idx = tim_step[IDX_W-1:0];

    always_comb begin
        ctl_d      = ctl_q;
        store_clr  = 1'b0;
        store_wr   = 1'b0;
        store_mask = 1'b0;
        tim_start  = 1'b0;
        unique case (ctl_q.st)
            PW_IDLE: begin
                if (wr_start_i) begin
                    if (ctl_q.wel) begin
                        ctl_d.st   = PW_FILL;
                        ctl_d.page = start_addr_i[ADDR_W-1:IDX_W];
                        ctl_d.ptr  = start_addr_i[IDX_W-1:0];
                        ctl_d.frac = '0;
                        store_clr  = 1'b1;
                    end
                end else if (wren_i) begin
                    ctl_d.wel = 1'b1;
                end else if (wrdi_i) begin
                    ctl_d.wel = 1'b0;
                end
            end
            PW_FILL: begin
                if (cs_rise_i) begin
                    if ((ctl_q.frac == '0) && (|slot_valid) && any_keep) begin
                        ctl_d.st   = PW_PROG;
                        store_mask = 1'b1;
                        tim_start  = 1'b1;
                    end else begin
                        ctl_d.st  = PW_IDLE;
                        store_clr = 1'b1;
                    end
                end else if (byte_stb_i) begin
                    store_wr   = 1'b1;
                    ctl_d.ptr  = ctl_q.ptr + 1'b1;
                    ctl_d.frac = '0;
                end else if (bit_stb_i) begin
                    ctl_d.frac = ctl_q.frac + 1'b1;
                end
            end
            PW_PROG: begin
                if (tim_done) begin
                    ctl_d.st  = PW_IDLE;
                    ctl_d.wel = 1'b0;
                    store_clr = 1'b1;
                end
            end
            default: begin
                ctl_d.st = PW_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: PW_IDLE, page: '0, ptr: '0, frac: '0, wel: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pwb_page_store #(
        .DATA_W (DATA_W),
        .SLOTS  (PAGE_BYTES),
        .IDX_W  (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (store_clr),
        .wr_i    (store_wr),
        .widx_i  (ctl_q.ptr),
        .wdata_i (byte_i),
        .mask_i  (store_mask),
        .keep_i  (slot_keep),
        .ridx_i  (walk_idx),
        .valid_o (slot_valid),
        .rdata_o (walk_data)
    );

    pwb_guard #(
        .ADDR_W (ADDR_W),
        .SLOTS  (PAGE_BYTES),
        .IDX_W  (IDX_W),
        .PAGE_W (PAGE_W)
    ) u_guard (
        .page_i      (ctl_q.page),
        .valid_i     (slot_valid),
        .prot_en_i   (prot_en_i),
        .whole_i     (prot_whole_i),
        .prot_base_i (prot_base_i),
        .keep_o      (slot_keep),
        .any_o       (any_keep)
    );

    pwb_timer #(
        .CNT_W (CNT_W),
        .SLOTS (PAGE_BYTES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tim_start),
        .len_i   (tprog_i),
        .busy_o  (tim_busy),
        .step_o  (tim_step),
        .done_o  (tim_done)
    );

    assign busy_o      = tim_busy;
    assign wel_o       = ctl_q.wel;
    assign mem_we_o    = tim_busy && (tim_step < CNT_W'(PAGE_BYTES)) && slot_valid[walk_idx];
    assign mem_addr_o  = {ctl_q.page, walk_idx};
    assign mem_wdata_o = walk_data;

    p_write_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    p_latch_held_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> wel_o);

    p_latch_drops_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !wel_o);

    p_no_start_unlatched_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == PW_IDLE && wr_start_i && !ctl_q.wel) |=> (ctl_q.st == PW_IDLE));

    p_ptr_wraps_in_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == PW_FILL && byte_stb_i && !cs_rise_i)
        |=> (ctl_q.ptr == IDX_W'($past(ctl_q.ptr) + 1'b1)) && $stable(ctl_q.page));

    p_misaligned_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == PW_FILL && cs_rise_i && ctl_q.frac != '0) |=> !busy_o);

    p_abort_keeps_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == PW_FILL && cs_rise_i && !busy_o) |=> (wel_o == $past(wel_o)));

    p_busy_ignores_latch_cmds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tim_done && (wren_i || wrdi_i)) |=> (wel_o == $past(wel_o)));

endmodule

// File: tb/page_write_commit_test.sv
module page_write_commit_test;

    localparam int AW = 11;
    localparam int DW = 8;
    localparam int PB = 32;
    localparam int CW = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          wr_start, bit_stb, byte_stb, cs_rise, wren, wrdi;
    logic [AW-1:0] start_addr, prot_base;
    logic [DW-1:0] byte_v;
    logic          prot_en, prot_whole;
    logic [CW-1:0] tprog;
    logic          busy_o, wel_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o;

    page_write_commit #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_start_i(wr_start), .start_addr_i(start_addr),
        .bit_stb_i(bit_stb), .byte_stb_i(byte_stb), .byte_i(byte_v), .cs_rise_i(cs_rise),
        .wren_i(wren), .wrdi_i(wrdi), .prot_en_i(prot_en), .prot_whole_i(prot_whole),
        .prot_base_i(prot_base), .tprog_i(tprog), .busy_o(busy_o), .wel_o(wel_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic [7:0] arr [0:(1<<AW)-1];

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural reference model, advanced on every rising edge
    int m_st, m_wel, m_page, m_ptr, m_frac, m_cnt, m_len;
    int m_dat [PB];
    bit m_val [PB];
    bit m_keep [PB];
    bit m_any, m_hit, m_anykeep;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_wel = 0; m_cnt = 0; m_len = 0; m_page = 0; m_ptr = 0; m_frac = 0;
            for (int i = 0; i < PB; i++) begin m_val[i] = 0; m_dat[i] = 0; end
        end else if (m_st == 0) begin
            if (wr_start) begin
                if (m_wel != 0) begin
                    m_st = 1; m_page = int'(start_addr) / PB; m_ptr = int'(start_addr) % PB; m_frac = 0;
                    for (int i = 0; i < PB; i++) m_val[i] = 0;
                end
            end else if (wren) m_wel = 1;
            else if (wrdi) m_wel = 0;
        end else if (m_st == 1) begin
            if (cs_rise) begin
                m_any = 0; m_hit = 0; m_anykeep = 0;
                for (int i = 0; i < PB; i++) begin
                    bit prot;
                    prot = prot_en && ((m_page * PB + i) >= int'(prot_base));
                    if (m_val[i]) m_any = 1;
                    if (m_val[i] && prot) m_hit = 1;
                    m_keep[i] = m_val[i] && !prot;
                end
                for (int i = 0; i < PB; i++) if (prot_whole && m_hit) m_keep[i] = 0;
                for (int i = 0; i < PB; i++) if (m_keep[i]) m_anykeep = 1;
                if (m_frac == 0 && m_any && m_anykeep) begin
                    m_st = 2; m_cnt = 0; m_len = (int'(tprog) < PB) ? PB : int'(tprog);
                    for (int i = 0; i < PB; i++) m_val[i] = m_keep[i];
                end else begin
                    m_st = 0;
                end
            end else if (byte_stb) begin
                m_dat[m_ptr] = int'(byte_v); m_val[m_ptr] = 1; m_ptr = (m_ptr + 1) % PB; m_frac = 0;
            end else if (bit_stb) begin
                m_frac = (m_frac + 1) % 8;
            end
        end else begin
            if (m_cnt == m_len - 1) begin
                m_st = 0; m_wel = 0;
                for (int i = 0; i < PB; i++) m_val[i] = 0;
            end else m_cnt++;
        end
    end

    // per-cycle comparison against the model; also records array writes
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit exp_we;
            exp_we = (m_st == 2) && (m_cnt < PB) && m_val[m_cnt % PB];
            chk("R7", int'(busy_o), int'(m_st == 2), "busy per cycle");
            chk("R2", int'(wel_o), m_wel, "latch per cycle");
            chk("R8", int'(mem_we_o), int'(exp_we), "write strobe per cycle");
            if (exp_we && mem_we_o) begin
                chk("R8", int'(mem_addr_o), m_page * PB + m_cnt, "write address");
                chk("R8", int'(mem_wdata_o), m_dat[m_cnt], "write data");
            end
            if (mem_we_o) arr[mem_addr_o] = mem_wdata_o;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_start(int a);
        start_addr = AW'(a); wr_start = 1'b1; tick(); wr_start = 1'b0;
    endtask

    task automatic do_byte(int b);
        for (int i = 0; i < 8; i++) begin
            bit_stb = 1'b1;
            if (i == 7) begin byte_stb = 1'b1; byte_v = DW'(b); end
            tick();
            bit_stb = 1'b0; byte_stb = 1'b0;
        end
    endtask

    task automatic do_bits(int n);
        for (int i = 0; i < n; i++) begin bit_stb = 1'b1; tick(); bit_stb = 1'b0; end
    endtask

    task automatic do_rise();
        cs_rise = 1'b1; tick(); cs_rise = 1'b0;
    endtask

    task automatic do_wren();
        wren = 1'b1; tick(); wren = 1'b0;
    endtask

    task automatic do_wrdi();
        wrdi = 1'b1; tick(); wrdi = 1'b0;
    endtask

    task automatic wait_prog(output int n);
        n = 0;
        while (busy_o) begin n++; tick(); end
        tick();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        int n;
        rst_n = 1'b0; wr_start = 0; bit_stb = 0; byte_stb = 0; cs_rise = 0; wren = 0; wrdi = 0;
        start_addr = '0; byte_v = '0; prot_en = 0; prot_whole = 0; prot_base = '0; tprog = CW'(40);
        for (int i = 0; i < (1 << AW); i++) arr[i] = 8'hFF;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1", int'(busy_o), 0, "busy after reset");
        chk("R1", int'(wel_o), 0, "latch after reset");
        chk("R1", int'(mem_we_o), 0, "strobe after reset");

        // write without the latch set
        do_start('h100); do_byte('h5A); do_byte('h5B); do_rise();
        chk("R3", int'(busy_o), 0, "busy after unlatched write");
        repeat (3) tick();
        chk("R3", int'(arr['h100]), 'hFF, "array after unlatched write");

        do_wren(); chk("R2", int'(wel_o), 1, "latch after set");
        do_wrdi(); chk("R2", int'(wel_o), 0, "latch after clear");
        do_wren();

        // wrap inside the page
        do_start('h21E); do_byte('hA1); do_byte('hA2); do_byte('hA3); do_rise();
        chk("R7", int'(busy_o), 1, "busy after commit");
        wait_prog(n);
        chk("R7", n, 40, "busy length tprog=40");
        chk("R4", int'(arr['h21E]), 'hA1, "first byte");
        chk("R4", int'(arr['h21F]), 'hA2, "second byte");
        chk("R4", int'(arr['h200]), 'hA3, "wrapped byte");
        chk("R4", int'(arr['h220]), 'hFF, "next page untouched");
        chk("R12", int'(wel_o), 0, "latch after programming");

        // more than one page of bytes overwrites earlier slots
        do_wren(); do_start('h040);
        for (int i = 0; i < 34; i++) do_byte(i + 'h10);
        do_rise(); wait_prog(n);
        chk("R4", int'(arr['h040]), 'h30, "slot 0 overwritten");
        chk("R4", int'(arr['h041]), 'h31, "slot 1 overwritten");
        chk("R4", int'(arr['h042]), 'h12, "slot 2 kept");
        chk("R4", int'(arr['h05F]), 'h2F, "last slot");

        // aborts before any whole byte
        do_wren(); do_start('h0A0); do_bits(3); do_rise();
        chk("R6", int'(busy_o), 0, "busy after partial-bit abort");
        do_start('h0A0); do_rise();
        chk("R6", int'(busy_o), 0, "busy after empty abort");
        chk("R6", int'(wel_o), 1, "latch after aborts");
        chk("R6", int'(arr['h0A0]), 'hFF, "array after aborts");

        // rise off a byte boundary
        do_start('h080); do_byte('h77); do_bits(3); do_rise();
        chk("R5", int'(busy_o), 0, "busy after misaligned rise");
        repeat (2) tick();
        chk("R5", int'(arr['h080]), 'hFF, "array after misaligned rise");
        chk("R5", int'(wel_o), 1, "latch after misaligned rise");

        // short programming time is floored at one page walk
        tprog = CW'(10);
        do_start('h300); do_byte('h55); do_rise(); wait_prog(n);
        chk("R7", n, 32, "busy length floor");
        chk("R8", int'(arr['h300]), 'h55, "single byte written");

        // activity during busy is ignored
        do_wren(); do_start('h301); do_byte('h56); do_rise();
        do_wrdi(); chk("R2", int'(wel_o), 1, "clear ignored while busy");
        do_start('h0C0); do_byte('h66); do_rise();
        wait_prog(n);
        chk("R13", int'(arr['h0C0]), 'hFF, "frame during busy dropped");
        chk("R8", int'(arr['h301]), 'h56, "committed byte written");

        // per-byte protection
        tprog = CW'(40); prot_en = 1; prot_base = AW'('h790); prot_whole = 0;
        do_wren(); do_start('h78E);
        do_byte('h01); do_byte('h02); do_byte('h03); do_byte('h04);
        do_rise(); wait_prog(n);
        chk("R9", int'(arr['h78E]), 'h01, "unprotected byte");
        chk("R9", int'(arr['h78F]), 'h02, "unprotected byte");
        chk("R9", int'(arr['h790]), 'hFF, "protected byte dropped");
        chk("R9", int'(arr['h791]), 'hFF, "protected byte dropped");

        // whole-page protection
        prot_whole = 1;
        do_wren(); do_start('h78E);
        do_byte('h09); do_byte('h0A); do_byte('h0B); do_byte('h0C);
        do_rise();
        chk("R10", int'(busy_o), 0, "no busy on page hit");
        chk("R11", int'(wel_o), 1, "latch kept on empty screen");
        chk("R10", int'(arr['h78E]), 'h01, "page left unchanged");
        do_start('h785); do_byte('h44); do_rise(); wait_prog(n);
        chk("R10", int'(arr['h785]), 'h44, "clean page written");

        // every byte protected in per-byte mode
        prot_whole = 0;
        do_wren(); do_start('h795); do_byte('h99); do_rise();
        chk("R11", int'(busy_o), 0, "no busy when nothing writable");
        chk("R11", int'(wel_o), 1, "latch kept");
        repeat (2) tick();
        chk("R9", int'(arr['h795]), 'hFF, "protected byte absent");

        finished = 1;
        summary();
        $finish;
    end

endmodule